// File: doc/BRIEF.md
# Resumable Non-Maskable Interrupt Register Unit

This block holds the three machine-level registers that a resumable non-maskable interrupt handler relies on. The first is a scratch word for saving context. The second is the saved program counter of the interrupted instruction. The third is the cause word that explains why the handler was entered. The block also holds the single enable bit that arms the interrupt. Software reaches the three registers through a simple register port with an address, write data, a write strobe and read data.

The trap logic outside the block raises a trap strobe. With it come the interrupted PC, a cause code, a flag that marks an interrupt as opposed to an exception, and a flag that marks a double trap. The block captures the PC with its alignment bits cleared and assembles the cause word itself. It then disarms the enable bit. When the handler finishes, a return strobe presents the saved PC on a next-PC output and re-arms the enable bit.

Two parameters shape the alignment and the cause format. One says whether compressed (16-bit) instructions exist; without them, PC bit 1 is also forced to zero. The other says whether interrupt cause codes are recorded.

Top module: `rnmi_csr_unit`

## Requirements
- R1: After reset the enable output is 0, and the scratch, saved-PC and cause registers all read as zero.
- R2: The scratch register (address 0x740) stores all XLEN bits written by software and is not changed by trap entry.
- R3: A trap strobe taken while enable is 1 loads the saved-PC register (address 0x741) with the trap PC after alignment masking, and clears enable at the next clock edge.
- R4: Bit 0 of the saved PC always reads 0, after both software writes and trap capture. When HAS_COMPRESSED is 0, bit 1 also always reads 0.
- R5: For a taken trap with the interrupt flag set and the double-trap flag clear, the cause register (address 0x742) gets bit XLEN-1 = 1. Its low bits hold the zero-extended cause code, or all zeros when HAS_CAUSE_CODES is 0.
- R6: For a taken trap with the double-trap flag set, cause bit XLEN-1 is 0 and the low bits hold the zero-extended cause code, whatever the interrupt flag says. The same encoding applies when both flags are clear.
- R7: A trap strobe that arrives while enable is 0 changes no register and leaves enable at 0.
- R8: If a taken trap and a software write hit the saved-PC or cause register in the same cycle, the trap capture is what gets stored.
- R9: While the return strobe is high, the next-PC output equals the masked saved PC in the same cycle. Enable becomes 1 at the next edge unless a trap is taken in that same cycle.
- R10: Reads are combinational from the stored values, and writes become visible only after the next clock edge. Any address other than the three mapped ones reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | XLEN | Write data |
| csr_we_i | input | 1 | Write strobe |
| csr_rdata_o | output | XLEN | Read data for csr_addr_i |
| trap_i | input | 1 | Trap-entry strobe |
| trap_pc_i | input | XLEN | PC of the interrupted instruction |
| trap_code_i | input | CODE_W | Cause code |
| trap_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_dbl_i | input | 1 | Trap is a double trap |
| ret_i | input | 1 | Return-from-handler strobe |
| ret_pc_o | output | XLEN | Masked saved PC (next PC on return) |
| nmi_en_o | output | 1 | Interrupt enable bit |

## Verification
The assertions check on every cycle the following behaviours:
- the low PC bits are forced to zero on the next-PC output;
- a taken trap clears enable and stores the masked trap PC;
- a trap arriving while enable is clear changes nothing;
- a return re-arms enable;
- unmapped addresses read zero.

Only the bench's scenarios can show the rest:
- the cause-word encodings across the interrupt, unsupported-code and double-trap cases;
- that the scratch register survives trap entry;
- that trap capture wins over a software write in the same cycle.

To cover both settings of each parameter, the bench runs a second instance built with both options off.

// File: rtl/rnmi_pkg.sv
package rnmi_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] ADDR_SCRATCH = 12'h740;
    localparam logic [ADDR_W-1:0] ADDR_EPC     = 12'h741;
    localparam logic [ADDR_W-1:0] ADDR_CAUSE   = 12'h742;

    typedef enum logic [1:0] {
        SEL_SCRATCH = 2'd0,
        SEL_EPC     = 2'd1,
        SEL_CAUSE   = 2'd2,
        SEL_NONE    = 2'd3
    } csr_sel_e;

endpackage

// File: rtl/rnmi_csr_decode.sv
module rnmi_csr_decode
    import rnmi_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output csr_sel_e          sel_o
);
    always_comb begin
        unique case (addr_i)
            ADDR_SCRATCH: sel_o = SEL_SCRATCH;
            ADDR_EPC:     sel_o = SEL_EPC;
            ADDR_CAUSE:   sel_o = SEL_CAUSE;
            default:      sel_o = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/rnmi_pc_align.sv
module rnmi_pc_align #(
    parameter int XLEN           = 32,
    parameter bit HAS_COMPRESSED = 1'b1
) (
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] pc_o
);
    // Only 2-byte alignment when short encodings exist, 4-byte otherwise.
    generate
        if (HAS_COMPRESSED) begin : g_half
            assign pc_o = {pc_i[XLEN-1:1], 1'b0};
        end else begin : g_word
            assign pc_o = {pc_i[XLEN-1:2], 2'b00};
        end
    endgenerate
endmodule

// File: rtl/rnmi_cause_build.sv
module rnmi_cause_build #(
    parameter int XLEN            = 32,
    parameter int CODE_W          = 8,
    parameter bit HAS_CAUSE_CODES = 1'b1
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              irq_i,
    input  logic              dbl_i,
    output logic [XLEN-1:0]   cause_o
);
    localparam int PAD_W = XLEN - 1 - CODE_W;

    logic              is_int;
    logic [CODE_W-1:0] low_code;

    // A double trap is always reported as an exception.
    assign is_int = irq_i & ~dbl_i;

    generate
        if (HAS_CAUSE_CODES) begin : g_codes
            assign low_code = code_i;
        end else begin : g_nocodes
            assign low_code = is_int ? '0 : code_i;
        end
    endgenerate

    assign cause_o = {is_int, {PAD_W{1'b0}}, low_code};
endmodule

// File: rtl/rnmi_csr_unit.sv
module rnmi_csr_unit
    import rnmi_pkg::*;
#(
    parameter int XLEN            = 32,
    parameter int CODE_W          = 8,
    parameter bit HAS_COMPRESSED  = 1'b1,
    parameter bit HAS_CAUSE_CODES = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [11:0]       csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    input  logic              csr_we_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    input  logic              trap_i,
    input  logic [XLEN-1:0]   trap_pc_i,
    input  logic [CODE_W-1:0] trap_code_i,
    input  logic              trap_irq_i,
    input  logic              trap_dbl_i,
    input  logic              ret_i,
    output logic [XLEN-1:0]   ret_pc_o,
    output logic              nmi_en_o
);

    typedef struct packed {
        logic [XLEN-1:0] scratch;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic            en;
    } state_t;

    state_t st_d, st_q;

    csr_sel_e        sel;
    logic            trap_take;
    logic [XLEN-1:0] wr_pc_al;
    logic [XLEN-1:0] trap_pc_al;
    logic [XLEN-1:0] epc_al;
    logic [XLEN-1:0] cause_new;

    rnmi_csr_decode u_dec (
        .addr_i (csr_addr_i),
        .sel_o  (sel)
    );

    rnmi_pc_align #(.XLEN(XLEN), .HAS_COMPRESSED(HAS_COMPRESSED)) u_al_wr (
        .pc_i (csr_wdata_i),
        .pc_o (wr_pc_al)
    );

    rnmi_pc_align #(.XLEN(XLEN), .HAS_COMPRESSED(HAS_COMPRESSED)) u_al_trap (
        .pc_i (trap_pc_i),
        .pc_o (trap_pc_al)
    );

    rnmi_pc_align #(.XLEN(XLEN), .HAS_COMPRESSED(HAS_COMPRESSED)) u_al_rd (
        .pc_i (st_q.epc),
        .pc_o (epc_al)
    );

    rnmi_cause_build #(
        .XLEN            (XLEN),
        .CODE_W          (CODE_W),
        .HAS_CAUSE_CODES (HAS_CAUSE_CODES)
    ) u_cause (
        .code_i  (trap_code_i),
        .irq_i   (trap_irq_i),
        .dbl_i   (trap_dbl_i),
        .cause_o (cause_new)
    );

    assign trap_take = trap_i & st_q.en;

    always_comb begin
        st_d = st_q;
        if (csr_we_i) begin
            unique case (sel)
                SEL_SCRATCH: st_d.scratch = csr_wdata_i;
                SEL_EPC:     st_d.epc     = wr_pc_al;
                SEL_CAUSE:   st_d.cause   = csr_wdata_i;
                default:     ;
            endcase
        end
        // Hardware capture is applied last, so it overrides software.
        if (trap_take) begin
            st_d.epc   = trap_pc_al;
            st_d.cause = cause_new;
            st_d.en    = 1'b0;
        end else if (ret_i) begin
            st_d.en    = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_SCRATCH: csr_rdata_o = st_q.scratch;
            SEL_EPC:     csr_rdata_o = epc_al;
            SEL_CAUSE:   csr_rdata_o = st_q.cause;
            default:     csr_rdata_o = '0;
        endcase
    end

    assign ret_pc_o = epc_al;
    assign nmi_en_o = st_q.en;

endmodule

// File: rtl/rnmi_csr_unit_chk.sv
module rnmi_csr_unit_chk
    import rnmi_pkg::*;
#(
    parameter int XLEN           = 32,
    parameter bit HAS_COMPRESSED = 1'b1
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [11:0]     csr_addr_i,
    input logic            csr_we_i,
    input logic [XLEN-1:0] csr_rdata_o,
    input logic            trap_i,
    input logic [XLEN-1:0] trap_pc_i,
    input logic            ret_i,
    input logic [XLEN-1:0] ret_pc_o,
    input logic            nmi_en_o
);
    localparam logic [XLEN-1:0] LOW_MASK = HAS_COMPRESSED ? XLEN'(1) : XLEN'(3);

    logic mapped;
    assign mapped = (csr_addr_i == ADDR_SCRATCH) || (csr_addr_i == ADDR_EPC) ||
                    (csr_addr_i == ADDR_CAUSE);

    p_pc_lsb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_pc_o & LOW_MASK) == '0);

    p_trap_clr_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i && nmi_en_o |=> !nmi_en_o);

    p_trap_pc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i && nmi_en_o |=> ret_pc_o == ($past(trap_pc_i) & ~LOW_MASK));

    p_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i && !nmi_en_o && !ret_i && !csr_we_i |=> $stable(ret_pc_o) && !nmi_en_o);

    p_ret_arms_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_i && !(trap_i && nmi_en_o) |=> nmi_en_o);

    p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mapped |-> csr_rdata_o == '0);

endmodule

bind rnmi_csr_unit rnmi_csr_unit_chk #(
    .XLEN           (XLEN),
    .HAS_COMPRESSED (HAS_COMPRESSED)
) chk_i (.*);

// File: tb/rnmi_csr_unit_tb_top.sv
module rnmi_csr_unit_tb_top;
    localparam int XLEN   = 32;
    localparam int CODE_W = 8;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic [11:0]       addr = '0;
    logic [XLEN-1:0]   wdata = '0;
    logic              we = 1'b0;
    logic              trap = 1'b0;
    logic [XLEN-1:0]   tpc = '0;
    logic [CODE_W-1:0] code = '0;
    logic              irq = 1'b0;
    logic              dbl = 1'b0;
    logic              ret = 1'b0;

    logic [XLEN-1:0] rd [2];
    logic [XLEN-1:0] rpc [2];
    logic            en [2];

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench model: index 0 = both options on, index 1 = both options off.
    logic [XLEN-1:0] m_scr [2];
    logic [XLEN-1:0] m_pc [2];
    logic [XLEN-1:0] m_cause [2];
    logic            m_en [2];

    always #2 clk = ~clk;

    rnmi_csr_unit #(.XLEN(XLEN), .CODE_W(CODE_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .csr_addr_i(addr), .csr_wdata_i(wdata),
        .csr_we_i(we), .csr_rdata_o(rd[0]), .trap_i(trap), .trap_pc_i(tpc),
        .trap_code_i(code), .trap_irq_i(irq), .trap_dbl_i(dbl), .ret_i(ret),
        .ret_pc_o(rpc[0]), .nmi_en_o(en[0]));

    rnmi_csr_unit #(.XLEN(XLEN), .CODE_W(CODE_W), .HAS_COMPRESSED(1'b0),
                    .HAS_CAUSE_CODES(1'b0)) dut_nc_i (
        .clk_i(clk), .rst_ni(rst_ni), .csr_addr_i(addr), .csr_wdata_i(wdata),
        .csr_we_i(we), .csr_rdata_o(rd[1]), .trap_i(trap), .trap_pc_i(tpc),
        .trap_code_i(code), .trap_irq_i(irq), .trap_dbl_i(dbl), .ret_i(ret),
        .ret_pc_o(rpc[1]), .nmi_en_o(en[1]));

    function automatic logic [XLEN-1:0] f_mask(logic [XLEN-1:0] pc, int cfg);
        return (cfg == 0) ? (pc & ~XLEN'(1)) : (pc & ~XLEN'(3));
    endfunction

    function automatic logic [XLEN-1:0] f_cause(logic [CODE_W-1:0] c, logic i, logic d, int cfg);
        logic intr;
        intr = i && !d;
        if (intr && cfg == 1) return {1'b1, {(XLEN-1){1'b0}}};
        return {intr, {(XLEN-1-CODE_W){1'b0}}, c};
    endfunction

    function automatic logic [XLEN-1:0] f_read(logic [11:0] a, int cfg);
        case (a)
            12'h740: return m_scr[cfg];
            12'h741: return f_mask(m_pc[cfg], cfg);
            12'h742: return m_cause[cfg];
            default: return '0;
        endcase
    endfunction

    task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        for (int c = 0; c < 2; c++) begin
            logic take;
            take = trap && m_en[c];
            if (we) begin
                case (addr)
                    12'h740: m_scr[c] = wdata;
                    12'h741: m_pc[c] = f_mask(wdata, c);
                    12'h742: m_cause[c] = wdata;
                    default: ;
                endcase
            end
            if (take) begin
                m_pc[c] = f_mask(tpc, c);
                m_cause[c] = f_cause(code, irq, dbl, c);
                m_en[c] = 1'b0;
            end else if (ret) begin
                m_en[c] = 1'b1;
            end
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, update model at posedge.
    task automatic cyc(logic [11:0] a, logic w, logic [XLEN-1:0] wd, logic t,
                       logic [XLEN-1:0] p, logic [CODE_W-1:0] cd, logic i, logic d, logic r);
        @(negedge clk);
        addr = a; we = w; wdata = wd; trap = t; tpc = p; code = cd; irq = i; dbl = d; ret = r;
        #1;
        for (int c = 0; c < 2; c++) begin
            check("R10 read", rd[c], f_read(a, c));
            check("R9 ret_pc", rpc[c], f_mask(m_pc[c], c));
            check("R3 enable", XLEN'(en[c]), XLEN'(m_en[c]));
        end
        @(posedge clk);
        model_step();
    endtask

    task automatic idle(logic [11:0] a);
        cyc(a, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic peek(logic [11:0] a);
        @(negedge clk);
        addr = a; we = 1'b0; trap = 1'b0; ret = 1'b0;
        #1;
    endtask

    initial begin
        int cycles = 0;
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                total++; bad++;
                $display("FAIL watchdog: actual=%0d expected<150000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        bit [31:0] seed;
        seed = $urandom(32'd2024);
        for (int c = 0; c < 2; c++) begin
            m_scr[c] = '0; m_pc[c] = '0; m_cause[c] = '0; m_en[c] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;

        // R1 reset state
        peek(12'h740); check("R1 scratch", rd[0], '0);
        peek(12'h741); check("R1 epc", rd[0], '0);
        peek(12'h742); check("R1 cause", rd[1], '0);
        check("R1 enable", XLEN'(en[0]), '0);

        // R9 return arms enable
        cyc(12'h7FF, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
        peek(12'h740); check("R9 armed", XLEN'(en[1]), XLEN'(1));

        // R2 / R10 scratch write visible after edge
        cyc(12'h740, 1'b1, 32'hDEAD_BEEF, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        peek(12'h740); check("R2 scratch", rd[0], 32'hDEAD_BEEF);

        // R3/R4/R5 interrupt entry
        cyc(12'h7FF, 1'b0, '0, 1'b1, 32'h0000_1003, 8'd5, 1'b1, 1'b0, 1'b0);
        peek(12'h741);
        check("R4 epc c", rd[0], 32'h0000_1002);
        check("R4 epc nc", rd[1], 32'h0000_1000);
        check("R3 disarmed", XLEN'(en[0]), '0);
        peek(12'h742);
        check("R5 cause codes", rd[0], 32'h8000_0005);
        check("R5 cause nocodes", rd[1], 32'h8000_0000);
        peek(12'h740); check("R2 kept on trap", rd[0], 32'hDEAD_BEEF);

        // R7 ignored while disarmed
        cyc(12'h7FF, 1'b0, '0, 1'b1, 32'h0000_2222, 8'd9, 1'b1, 1'b0, 1'b0);
        peek(12'h741); check("R7 epc kept", rd[0], 32'h0000_1002);
        peek(12'h742); check("R7 cause kept", rd[0], 32'h8000_0005);

        // R6 double trap
        cyc(12'h7FF, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
        cyc(12'h7FF, 1'b0, '0, 1'b1, 32'h0000_0040, 8'h10, 1'b1, 1'b1, 1'b0);
        peek(12'h742);
        check("R6 dbl codes", rd[0], 32'h0000_0010);
        check("R6 dbl nocodes", rd[1], 32'h0000_0010);

        // R8 trap beats same-cycle write
        cyc(12'h7FF, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
        cyc(12'h741, 1'b1, 32'h0000_5555, 1'b1, 32'h0000_3000, 8'd2, 1'b0, 1'b0, 1'b0);
        peek(12'h741); check("R8 epc trap wins", rd[0], 32'h0000_3000);
        peek(12'h742); check("R6 exception cause", rd[1], 32'h0000_0002);

        // R10 unmapped address
        cyc(12'h7FF, 1'b1, 32'hFFFF_FFFF, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        peek(12'h7FF); check("R10 unmapped", rd[0], '0);

        // R4 software write masking
        cyc(12'h741, 1'b1, 32'hFFFF_FFFF, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        peek(12'h741);
        check("R4 sw c", rd[0], 32'hFFFF_FFFE);
        check("R4 sw nc", rd[1], 32'hFFFF_FFFC);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic [11:0] a;
            case ($urandom_range(3))
                0: a = 12'h740;
                1: a = 12'h741;
                2: a = 12'h742;
                default: a = 12'h7FF;
            endcase
            cyc(a, $urandom_range(2) == 0, $urandom, $urandom_range(3) == 0, $urandom,
                CODE_W'($urandom), 1'($urandom), $urandom_range(4) == 0, $urandom_range(3) == 0);
        end
        idle(12'h740);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule